// File: doc/BRIEF.md
# Multi-Flow Prioritized Bridge Buffer

This block sits between one shared peripheral and the system interconnect. Each descriptor arrives with a flow tag that names a virtual device. The descriptor's source and destination addresses go into that flow's paired queue. Each flow has a fixed priority, and a lower flow index means a higher priority. An external scheduler controls a bus grant. While the grant is low, queued work is held and nothing is lost. While the grant is high, the block offers one transfer per cycle, taken from the head of the highest-priority flow that has entries. The transfer is consumed only when the target accepts it.

Per-flow status gives three things: an occupancy count, a full flag, and a sticky flag recording that a descriptor was offered to a full flow. A synchronous clear input empties every queue and resets the sticky flags.

Top module: `flow_bridge_buf`

## Requirements
- R1: A descriptor accepted with tag f (desc_valid_i and desc_ready_o both high at a clock edge) is stored only in flow f's queue. It becomes eligible for issue from the next cycle on.
- R2: When more than one flow holds entries, the transfer offered comes from the lowest-numbered non-empty flow. Flow 0 is the highest priority.
- R3: Within one flow, transfers are issued in the order the descriptors were accepted.
- R4: The source and destination addresses of a descriptor are stored and issued together, as one transfer on xfer_src_o and xfer_dst_o.
- R5: While grant_i is low, xfer_valid_o is low and every queued entry is kept.
- R6: desc_ready_o is high exactly when clr_i is low and the queue of the flow named by desc_flow_i holds fewer than DEPTH entries. flow_full_o bit f is high exactly when flow f holds DEPTH entries.
- R7: A descriptor offered to a full flow is not stored, and no stored entry is overwritten.
- R8: xfer_valid_o is high only when grant_i is high, clr_i is low and some flow is non-empty. A transfer is consumed when xfer_valid_o and xfer_ready_i are both high. At most one transfer is consumed per cycle.
- R9: flow_count_o field f, at bits [f*CNT_W +: CNT_W], equals the number of entries held by flow f.
- R10: flow_ovf_o bit f is set in the cycle after desc_valid_i is high with tag f while flow f is full and clr_i is low. Once set, it stays set until a clear.
- R11: clr_i high at a clock edge empties all flows and resets all overflow flags. During a clear cycle, nothing is accepted and nothing is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous flush of queues and overflow flags |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_flow_i | input | FLOW_W | Flow tag of the descriptor |
| desc_src_i | input | ADDR_W | Source address |
| desc_dst_i | input | ADDR_W | Destination address |
| desc_ready_o | output | 1 | Tagged flow can accept a descriptor |
| grant_i | input | 1 | Bus grant from the external scheduler |
| xfer_ready_i | input | 1 | Target accepts the offered transfer |
| xfer_valid_o | output | 1 | Transfer offered |
| xfer_flow_o | output | FLOW_W | Flow the offered transfer comes from |
| xfer_src_o | output | ADDR_W | Source address of the offered transfer |
| xfer_dst_o | output | ADDR_W | Destination address of the offered transfer |
| flow_count_o | output | NUM_FLOWS*CNT_W | Per-flow occupancy, field f at [f*CNT_W +: CNT_W] |
| flow_full_o | output | NUM_FLOWS | Per-flow full flag |
| flow_ovf_o | output | NUM_FLOWS | Per-flow sticky overflow-attempt flag |

## Verification
The bench builds the block with NUM_FLOWS=4, DEPTH=4 and ADDR_W=16. At that depth a short burst is enough to reach a full flow, so rejected descriptors, overflow flags and the full-to-draining transition occur many times in the random phase. Four flows are enough to produce contention with up to four levels of priority. The grant and the target ready are randomized independently, so hold periods and back-pressure interleave with pushes and pops to the same flow.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int unsigned FBB_FLOWS_DEF = 4;
  localparam int unsigned FBB_DEPTH_DEF = 8;
  localparam int unsigned FBB_ADDR_DEF  = 32;
endpackage

// File: rtl/fbb_pair_fifo.sv
module fbb_pair_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [ADDR_W-1:0] src_mem [DEPTH];
  logic [ADDR_W-1:0] dst_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign src_o   = src_mem[rd_ptr];
  assign dst_o   = dst_mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      if (push_i && !pop_i)      count_o <= count_o + 1'b1;
      else if (pop_i && !push_i) count_o <= count_o - 1'b1;
    end
  end

  // source and destination share one write pointer: they cannot diverge
  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) begin
      src_mem[wr_ptr] <= src_i;
      dst_mem[wr_ptr] <= dst_i;
    end
  end

  assert_no_overwrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  assert_pop_drops_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clr_i) |=> (count_o == $past(count_o) - 1'b1));
  assert_clear_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/fbb_prio_pick.sv
module fbb_prio_pick #(
  parameter int unsigned NUM_FLOWS = 4,
  localparam int unsigned FLOW_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic [NUM_FLOWS-1:0] req_i,
  output logic                 any_o,
  output logic [FLOW_W-1:0]    idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_FLOWS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = FLOW_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/flow_bridge_buf.sv
module flow_bridge_buf #(
  parameter int unsigned NUM_FLOWS = fbb_pkg::FBB_FLOWS_DEF,
  parameter int unsigned DEPTH     = fbb_pkg::FBB_DEPTH_DEF,
  parameter int unsigned ADDR_W    = fbb_pkg::FBB_ADDR_DEF,
  localparam int unsigned FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       desc_valid_i,
  input  logic [FLOW_W-1:0]          desc_flow_i,
  input  logic [ADDR_W-1:0]          desc_src_i,
  input  logic [ADDR_W-1:0]          desc_dst_i,
  output logic                       desc_ready_o,
  input  logic                       grant_i,
  input  logic                       xfer_ready_i,
  output logic                       xfer_valid_o,
  output logic [FLOW_W-1:0]          xfer_flow_o,
  output logic [ADDR_W-1:0]          xfer_src_o,
  output logic [ADDR_W-1:0]          xfer_dst_o,
  output logic [NUM_FLOWS*CNT_W-1:0] flow_count_o,
  output logic [NUM_FLOWS-1:0]       flow_full_o,
  output logic [NUM_FLOWS-1:0]       flow_ovf_o
);
  logic [NUM_FLOWS-1:0] push, pop, empty, nonempty;
  logic [ADDR_W-1:0]    head_src [NUM_FLOWS];
  logic [ADDR_W-1:0]    head_dst [NUM_FLOWS];
  logic                 any_ne, fire;
  logic [FLOW_W-1:0]    pick;

  assign desc_ready_o = !clr_i && !flow_full_o[desc_flow_i];
  assign nonempty     = ~empty;
  assign xfer_valid_o = grant_i && !clr_i && any_ne;
  assign fire         = xfer_valid_o && xfer_ready_i;
  assign xfer_flow_o  = pick;
  assign xfer_src_o   = head_src[pick];
  assign xfer_dst_o   = head_dst[pick];

  fbb_prio_pick #(.NUM_FLOWS(NUM_FLOWS)) u_pick (
    .req_i (nonempty),
    .any_o (any_ne),
    .idx_o (pick)
  );

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    assign push[f] = desc_valid_i && desc_ready_o && (desc_flow_i == FLOW_W'(f));
    assign pop[f]  = fire && (pick == FLOW_W'(f));

    fbb_pair_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .push_i  (push[f]),
      .src_i   (desc_src_i),
      .dst_i   (desc_dst_i),
      .pop_i   (pop[f]),
      .src_o   (head_src[f]),
      .dst_o   (head_dst[f]),
      .count_o (flow_count_o[f*CNT_W +: CNT_W]),
      .empty_o (empty[f]),
      .full_o  (flow_full_o[f])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flow_ovf_o[f] <= 1'b0;
      else if (clr_i) flow_ovf_o[f] <= 1'b0;
      else if (desc_valid_i && desc_flow_i == FLOW_W'(f) && flow_full_o[f])
        flow_ovf_o[f] <= 1'b1;
    end

    assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flow_ovf_o[f] && !clr_i) |=> flow_ovf_o[f]);
    assert_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_valid_o && nonempty[f]) |-> (xfer_flow_o <= FLOW_W'(f)));
  end

  assert_grant_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> grant_i);
  assert_single_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop));
  assert_single_push_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_i && !clr_i && !desc_valid_i) |=> $stable(flow_count_o));
endmodule

// File: tb/tb_flow_bridge_buf.sv
module tb_flow_bridge_buf;
  localparam int NF = 4;
  localparam int DP = 4;
  localparam int AW = 16;
  localparam int FW = 2;
  localparam int CW = $clog2(DP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr, dv, g, xr;
  logic [FW-1:0] df;
  logic [AW-1:0] ds, dd;
  logic d_rdy, xv;
  logic [FW-1:0] xf;
  logic [AW-1:0] xs, xd;
  logic [NF*CW-1:0] cnt;
  logic [NF-1:0] full, ovf;

  always #2 clk = ~clk;

  flow_bridge_buf #(.NUM_FLOWS(NF), .DEPTH(DP), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .desc_valid_i(dv), .desc_flow_i(df), .desc_src_i(ds), .desc_dst_i(dd),
    .desc_ready_o(d_rdy), .grant_i(g), .xfer_ready_i(xr),
    .xfer_valid_o(xv), .xfer_flow_o(xf), .xfer_src_o(xs), .xfer_dst_o(xd),
    .flow_count_o(cnt), .flow_full_o(full), .flow_ovf_o(ovf)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_src [NF][DP];
  logic [AW-1:0] m_dst [NF][DP];
  int m_hd [NF];
  int m_n  [NF];
  bit m_ovf [NF];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick_flow();
    int p = -1;
    for (int f = NF - 1; f >= 0; f--) if (m_n[f] != 0) p = f;
    return p;
  endfunction

  task automatic step(input bit v, input int f, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input bit gr, input bit rd, input bit c);
    int p;
    bit e_rdy, e_xv, acc, fire;
    @(negedge clk);
    dv = v; df = FW'(f); ds = s; dd = d; g = gr; xr = rd; clr = c;
    #1;
    p = pick_flow();
    e_rdy = !c && (m_n[f] < DP);
    e_xv  = !c && gr && (p >= 0);
    chk(d_rdy == e_rdy, "R6 desc_ready", 64'(d_rdy), 64'(e_rdy));
    chk(xv == e_xv, "R5/R8 xfer_valid", 64'(xv), 64'(e_xv));
    if (e_xv) begin
      chk(xf == FW'(p), "R2 xfer_flow", 64'(xf), 64'(p));
      chk(xs == m_src[p][m_hd[p]], "R3 xfer_src order", 64'(xs), 64'(m_src[p][m_hd[p]]));
      chk(xd == m_dst[p][m_hd[p]], "R4 xfer_dst pairing", 64'(xd), 64'(m_dst[p][m_hd[p]]));
    end
    for (int k = 0; k < NF; k++) begin
      chk(cnt[k*CW +: CW] == CW'(m_n[k]), "R9 count", 64'(cnt[k*CW +: CW]), 64'(m_n[k]));
      chk(full[k] == (m_n[k] == DP), "R6 full", 64'(full[k]), 64'(m_n[k] == DP));
      chk(ovf[k] == m_ovf[k], "R10 ovf", 64'(ovf[k]), 64'(m_ovf[k]));
    end
    @(posedge clk);
    if (c) begin
      for (int k = 0; k < NF; k++) begin m_n[k] = 0; m_hd[k] = 0; m_ovf[k] = 0; end
    end else begin
      acc  = v && (m_n[f] < DP);
      fire = e_xv && rd;
      if (v && m_n[f] == DP) m_ovf[f] = 1;
      if (acc) begin
        m_src[f][(m_hd[f] + m_n[f]) % DP] = s;
        m_dst[f][(m_hd[f] + m_n[f]) % DP] = d;
        m_n[f]++;
      end
      if (fire) begin
        m_hd[p] = (m_hd[p] + 1) % DP;
        m_n[p]--;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NF; k++) begin m_n[k] = 0; m_hd[k] = 0; m_ovf[k] = 0; end
    clr = 0; dv = 0; df = '0; ds = '0; dd = '0; g = 0; xr = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state
    step(0, 0, 0, 0, 0, 0, 0);
    // R5 R6 R7 R10: fill flow 2 with grant low, then overflow
    for (int i = 0; i < DP + 2; i++) step(1, 2, AW'(16'h2000 + i), AW'(16'h2100 + i), 0, 1, 0);
    // R1: other flows tagged while held
    step(1, 3, 16'h3000, 16'h3100, 0, 1, 0);
    step(1, 1, 16'h1000, 16'h1100, 0, 1, 0);
    step(1, 1, 16'h1001, 16'h1101, 0, 1, 0);
    // R8: grant but target stalls
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    // R2 R3 R4: drain in priority order, a flow 0 arrival mid-drain
    step(0, 0, 0, 0, 1, 1, 0);
    step(1, 0, 16'h0AAA, 16'h0BBB, 1, 1, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 1, 0);
    // R10 R11: overflow then clear
    for (int i = 0; i < DP + 1; i++) step(1, 0, AW'(i), AW'(i), 0, 0, 0);
    step(1, 0, 16'h1234, 16'h4321, 1, 1, 1);
    step(0, 0, 0, 0, 1, 1, 0);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      step(($urandom % 3) != 0, int'($urandom % NF), AW'($urandom), AW'($urandom),
           ($urandom % 4) != 0 ? (i % 400 > 150) : 1'b0, ($urandom % 3) != 0,
           ($urandom % 500) == 0);
    end
    for (int i = 0; i < 4 * DP + 4; i++) step(0, 0, 0, 0, 1, 1, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule